// File: doc/BRIEF.md
# Single-Operand Integer Unit

This unit runs one of four single-operand integer operations on a 32-bit register value: subtract-from-zero with the extend flag folded in, clear, plain subtract-from-zero, and bitwise complement. The operation works at byte, word or long width. Only the selected low lanes are rewritten; the higher bits of the value come back as they went in. The condition flags are computed at the selected width and returned as a new five-bit flag word.

The sequencer raises `start_i` for one cycle with the operand, the current flag word, the operation, the size and a flag that marks an operand fetched from memory. The unit captures its result at that edge. It then raises `done_o` for one cycle after the operation's cycle cost has elapsed, so the sequencer can pace instruction timing from the pulse. A start with the reserved size code is reported at once and leaves the flags untouched.

Top module: `unop_unit`

## Requirements
- R1: With `op_i` = 1 (clear), the low lanes of the selected size become zero and the flag word `ccr` = {X,N,Z,V,C} (bit 4 down to bit 0) returns N=0, Z=1, V=0, C=0 with X copied from `ccr_i[4]`.
- R2: With `op_i` = 0 (extended negate), the result is 0 minus the operand minus `ccr_i[4]`. C and X both equal the borrow. Z is cleared when the result is nonzero and otherwise keeps `ccr_i[2]`. V is set when the operand and the result both have their top bit set.
- R3: With `op_i` = 2 (negate), the result is 0 minus the operand. C and X are set exactly when the operand is nonzero, and V is set only for the most negative operand.
- R4: With `op_i` = 3 (complement), the result is the bitwise inverse of the operand. N and Z follow the result, V and C are cleared, and X keeps `ccr_i[4]`.
- R5: `size_i` selects byte (0), word (1) or long (2). N is taken from bit 7, 15 or 31, and Z, V and C are judged on that width only.
- R6: For byte and word sizes, the result bits above the operand width equal the operand bits.
- R7: `done_o` is high for exactly one cycle. It rises at the clock edge that comes COST edges after the edge that samples `start_i`. COST is 4 for byte or word and 6 for long, and it doubles when `mem_i` is 1.
- R8: With `size_i` = 3, `illegal_o` and `done_o` rise at the edge that samples `start_i`. `ccr_o` equals `ccr_i` and `result_o` equals the operand.
- R9: A `start_i` that arrives while an operation is still counting is ignored. It changes neither the result, nor the flags, nor the timing of the pending `done_o`.
- R10: After reset, `done_o`, `illegal_o`, `result_o` and `ccr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch an operation |
| op_i | input | 2 | Operation: 0 extended negate, 1 clear, 2 negate, 3 complement |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 reserved |
| mem_i | input | 1 | Operand comes from memory (doubles cost) |
| operand_i | input | 32 | Register value to operate on |
| ccr_i | input | 5 | Current flags {X,N,Z,V,C} |
| result_o | output | 32 | Merged result |
| ccr_o | output | 5 | Updated flags {X,N,Z,V,C} |
| illegal_o | output | 1 | Reserved size was requested |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can meet in one cycle: a fresh `start_i` and an operation that is still counting down. The bench provokes this by pulsing `start_i` one cycle after a launch, with a different operand and a different operation. It judges the outcome by requiring that the pending pulse keeps its expected latency and carries the result and flags of the first request only. A second overlap occurs when the extended negate's sticky Z meets a zero result. The bench drives this with both values of the incoming Z and checks that Z passes through unchanged.

// File: rtl/unop_pkg.sv
package unop_pkg;

   localparam int UNOP_DW   = 32;
   localparam int BYTE_W    = 8;
   localparam int NUM_SIZES = 3;

   typedef enum logic [1:0] {
      OP_NEGX = 2'd0,
      OP_CLR  = 2'd1,
      OP_NEG  = 2'd2,
      OP_NOT  = 2'd3
   } unop_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } unop_size_e;

   // flag word bit positions
   localparam int F_X = 4;
   localparam int F_N = 3;
   localparam int F_Z = 2;
   localparam int F_V = 1;
   localparam int F_C = 0;

   typedef struct packed {
      logic [UNOP_DW-1:0] res;
      logic               neg;
      logic               zero;
      logic               ovf;
      logic               borrow;
   } lane_t;

endpackage

// File: rtl/unop_datapath.sv
module unop_datapath
   import unop_pkg::*;
#(
   parameter int DATA_W = UNOP_DW
) (
   input  unop_op_e         op,
   input  unop_size_e       sz,
   input  logic [DATA_W-1:0] a,
   input  logic             x_in,
   output lane_t            lane_o
);

   lane_t lanes [NUM_SIZES];

   logic is_sub;
   assign is_sub = (op == OP_NEGX) || (op == OP_NEG);

   logic carry_in;
   assign carry_in = (op == OP_NEGX) ? x_in : 1'b0;

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
      localparam int W = BYTE_W << g;
      logic [W:0]        diff;
      logic [W-1:0]      lres;
      logic [DATA_W-1:0] mask;

      assign mask = DATA_W'({W{1'b1}});
      assign diff = (W+1)'(0) - {1'b0, a[W-1:0]} - (W+1)'(carry_in);

      always_comb begin
         unique case (op)
            OP_CLR:  lres = '0;
            OP_NOT:  lres = ~a[W-1:0];
            default: lres = diff[W-1:0];
         endcase
      end

      assign lanes[g].res    = (a & ~mask) | DATA_W'(lres);
      assign lanes[g].neg    = lres[W-1];
      assign lanes[g].zero   = (lres == '0);
      assign lanes[g].ovf    = is_sub & a[W-1] & lres[W-1];
      assign lanes[g].borrow = is_sub & diff[W];
   end

   always_comb begin
      unique case (sz)
         SZ_BYTE: lane_o = lanes[0];
         SZ_WORD: lane_o = lanes[1];
         SZ_LONG: lane_o = lanes[2];
         default: lane_o = '{res: a, neg: 1'b0, zero: 1'b0, ovf: 1'b0, borrow: 1'b0};
      endcase
   end

endmodule

// File: rtl/unop_flags.sv
module unop_flags
   import unop_pkg::*;
(
   input  unop_op_e   op,
   input  lane_t      lane,
   input  logic [4:0] ccr_in,
   output logic [4:0] ccr_out
);

   always_comb begin
      ccr_out = ccr_in;
      unique case (op)
         OP_CLR: begin
            ccr_out[F_N] = 1'b0;
            ccr_out[F_Z] = 1'b1;
            ccr_out[F_V] = 1'b0;
            ccr_out[F_C] = 1'b0;
         end
         OP_NOT: begin
            ccr_out[F_N] = lane.neg;
            ccr_out[F_Z] = lane.zero;
            ccr_out[F_V] = 1'b0;
            ccr_out[F_C] = 1'b0;
         end
         OP_NEG: begin
            ccr_out[F_X] = lane.borrow;
            ccr_out[F_N] = lane.neg;
            ccr_out[F_Z] = lane.zero;
            ccr_out[F_V] = lane.ovf;
            ccr_out[F_C] = lane.borrow;
         end
         default: begin
            ccr_out[F_X] = lane.borrow;
            ccr_out[F_N] = lane.neg;
            ccr_out[F_Z] = ccr_in[F_Z] & lane.zero;
            ccr_out[F_V] = lane.ovf;
            ccr_out[F_C] = lane.borrow;
         end
      endcase
   end

endmodule

// File: rtl/unop_timer.sv
module unop_timer #(
   parameter int CNT_W   = 4,
   parameter int MAX_CYC = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             flash,
   input  logic [CNT_W-1:0] cost,
   output logic             busy,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= flash || (cnt_q == CNT_W'(1));
         if (launch)    cnt_q <= cost;
         else if (busy) cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_CYC)) else $error("counter out of range"); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done && !flash |=> !done) else $error("done longer than one cycle"); // R7

endmodule

// File: rtl/unop_unit.sv
module unop_unit
   import unop_pkg::*;
#(
   parameter int DATA_W    = UNOP_DW,
   parameter int CYC_SHORT = 4,
   parameter int CYC_LONG  = 6,
   parameter int MEM_SHIFT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [1:0]        size_i,
   input  logic              mem_i,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [4:0]        ccr_i,
   output logic [DATA_W-1:0] result_o,
   output logic [4:0]        ccr_o,
   output logic              illegal_o,
   output logic              done_o
);

   localparam int MAX_CYC = CYC_LONG << MEM_SHIFT;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   initial begin
      assert (DATA_W == UNOP_DW) else $error("DATA_W must match package width");
      assert (CYC_SHORT > 0 && CYC_LONG >= CYC_SHORT) else $error("bad cycle costs");
   end

   unop_op_e   op;
   unop_size_e sz;
   assign op = unop_op_e'(op_i);
   assign sz = unop_size_e'(size_i);

   lane_t      lane;
   logic [4:0] ccr_new;
   logic       busy;
   logic       accept;
   logic       bad_size;
   logic [CNT_W-1:0] base_cost;
   logic [CNT_W-1:0] cost;

   unop_datapath #(.DATA_W(DATA_W)) u_dp (
      .op     (op),
      .sz     (sz),
      .a      (operand_i),
      .x_in   (ccr_i[F_X]),
      .lane_o (lane)
   );

   unop_flags u_flags (
      .op      (op),
      .lane    (lane),
      .ccr_in  (ccr_i),
      .ccr_out (ccr_new)
   );

   assign bad_size  = (sz == SZ_RSVD);
   assign accept    = start_i && !busy;
   assign base_cost = (sz == SZ_LONG) ? CNT_W'(CYC_LONG) : CNT_W'(CYC_SHORT);
   assign cost      = mem_i ? (base_cost << MEM_SHIFT) : base_cost;

   unop_timer #(.CNT_W(CNT_W), .MAX_CYC(MAX_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (accept && !bad_size),
      .flash  (accept && bad_size),
      .cost   (cost),
      .busy   (busy),
      .done   (done_o)
   );

   logic [DATA_W-1:0] res_q;
   logic [DATA_W-1:0] opnd_q;
   logic [4:0]        ccr_q;
   logic [4:0]        ccr_in_q;
   logic              ill_q;
   unop_op_e          op_q;
   unop_size_e        sz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q    <= '0;
         opnd_q   <= '0;
         ccr_q    <= '0;
         ccr_in_q <= '0;
         ill_q    <= 1'b0;
         op_q     <= OP_NEGX;
         sz_q     <= SZ_BYTE;
      end else if (accept) begin
         res_q    <= bad_size ? operand_i : lane.res;
         opnd_q   <= operand_i;
         ccr_q    <= bad_size ? ccr_i : ccr_new;
         ccr_in_q <= ccr_i;
         ill_q    <= bad_size;
         op_q     <= op;
         sz_q     <= sz;
      end
   end

   assign result_o  = res_q;
   assign ccr_o     = ccr_q;
   assign illegal_o = ill_q;

   AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !illegal_o && op_q == OP_CLR |->
         ccr_o[3:0] == 4'b0100 && ccr_o[F_X] == ccr_in_q[F_X]) else $error("clear flags"); // R1

   AST_NOT_CV: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !illegal_o && op_q == OP_NOT |->
         !ccr_o[F_V] && !ccr_o[F_C] && ccr_o[F_X] == ccr_in_q[F_X]) else $error("complement flags"); // R4

   AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && sz_q == SZ_BYTE |-> result_o[DATA_W-1:8] == opnd_q[DATA_W-1:8]) else $error("upper bits"); // R6

   AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      accept && bad_size |=> done_o && illegal_o && ccr_o == $past(ccr_i)) else $error("illegal size"); // R8

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && busy |=> $stable(res_q) && $stable(ccr_q)) else $error("start while busy"); // R9

endmodule

// File: tb/unop_unit_tb.sv
module unop_unit_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = '0;
   logic [1:0]  size_i = '0;
   logic        mem_i = 1'b0;
   logic [31:0] operand_i = '0;
   logic [4:0]  ccr_i = '0;
   logic [31:0] result_o;
   logic [4:0]  ccr_o;
   logic        illegal_o;
   logic        done_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   unop_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .op_i      (op_i),
      .size_i    (size_i),
      .mem_i     (mem_i),
      .operand_i (operand_i),
      .ccr_i     (ccr_i),
      .result_o  (result_o),
      .ccr_o     (ccr_o),
      .illegal_o (illegal_o),
      .done_o    (done_o)
   );

   // returns {illegal, ccr[4:0], result[31:0]}
   function automatic logic [37:0] model(input logic [1:0] op, input logic [1:0] sz,
                                         input logic [31:0] a, input logic [4:0] ccr);
      logic [31:0] mask, am, r, msb;
      logic        xx, brw, n, z, v;
      logic [4:0]  f;
      int          w;
      if (sz == 2'd3) return {1'b1, ccr, a};
      w    = 8 << sz;
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      msb  = 32'd1 << (w - 1);
      am   = a & mask;
      xx   = ccr[4];
      brw  = 1'b0;
      case (op)
         2'd0: begin r = (32'd0 - am - {31'd0, xx}) & mask; brw = (am != 0) || xx; end
         2'd2: begin r = (32'd0 - am) & mask; brw = (am != 0); end
         2'd1: r = 32'd0;
         default: r = ~am & mask;
      endcase
      n = (r & msb) != 0;
      z = (r == 0);
      v = (op == 2'd0 || op == 2'd2) && ((am & msb) != 0) && ((r & msb) != 0);
      case (op)
         2'd0: f = {brw, n, ccr[2] & z, v, brw};
         2'd1: f = {ccr[4], 4'b0100};
         2'd2: f = {brw, n, z, v, brw};
         default: f = {ccr[4], n, z, 2'b00};
      endcase
      return {1'b0, f, (a & ~mask) | r};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic [1:0] op, input logic [1:0] sz,
                        input logic mem, input logic [31:0] a, input logic [4:0] ccr,
                        input bit intrude);
      logic [37:0] exp;
      int lat, exp_lat;
      exp     = model(op, sz, a, ccr);
      exp_lat = (sz == 2'd3) ? 0 : (((sz == 2'd2) ? 6 : 4) << mem);
      @(negedge clk);
      op_i = op; size_i = sz; mem_i = mem; operand_i = a; ccr_i = ccr; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 40) begin
         if (intrude && lat == 1) begin
            start_i = 1'b1; operand_i = ~a; op_i = op ^ 2'd3; ccr_i = ~ccr;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start_i = 1'b0;
      check({req, " latency"}, 64'(lat), 64'(exp_lat));
      check({req, " result"}, 64'(result_o), 64'(exp[31:0]));
      check({req, " flags"}, 64'(ccr_o), 64'(exp[36:32]));
      check({req, " illegal"}, 64'(illegal_o), 64'(exp[37]));
      @(negedge clk);
      check({req, " done pulse width"}, 64'(done_o), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 done", 64'(done_o), 64'd0);
      check("R10 illegal", 64'(illegal_o), 64'd0);
      check("R10 result", 64'(result_o), 64'd0);
      check("R10 flags", 64'(ccr_o), 64'd0);

      // R1 clear, byte with upper bits kept (R6)
      apply("R1", 2'd1, 2'd0, 1'b0, 32'hDEAD_BEEF, 5'b10011, 0);
      apply("R1 long mem", 2'd1, 2'd2, 1'b1, 32'h1234_5678, 5'b01000, 0);
      // R2 extended negate, sticky Z both ways
      apply("R2 zero keepZ", 2'd0, 2'd1, 1'b0, 32'hABCD_0000, 5'b00100, 0);
      apply("R2 zero clrZ", 2'd0, 2'd1, 1'b0, 32'hABCD_0000, 5'b00000, 0);
      apply("R2 x borrow", 2'd0, 2'd0, 1'b0, 32'h0000_0000, 5'b10100, 0);
      apply("R2 long", 2'd0, 2'd2, 1'b1, 32'h0000_0001, 5'b10100, 0);
      // R3 negate: most negative and zero
      apply("R3 minbyte", 2'd2, 2'd0, 1'b0, 32'h1111_1180, 5'b00000, 0);
      apply("R3 zero", 2'd2, 2'd2, 1'b0, 32'h0000_0000, 5'b11111, 0);
      apply("R3 minlong", 2'd2, 2'd2, 1'b1, 32'h8000_0000, 5'b00000, 0);
      // R4 complement
      apply("R4", 2'd3, 2'd1, 1'b0, 32'h5555_FFFF, 5'b10011, 0);
      // R5 width: bit 7 set but word sized
      apply("R5 word", 2'd3, 2'd1, 1'b1, 32'h0000_FF7F, 5'b00000, 0);
      // R6 upper bits
      apply("R6 word", 2'd2, 2'd1, 1'b0, 32'hCAFE_0001, 5'b00000, 0);
      // R8 illegal size
      apply("R8", 2'd2, 2'd3, 1'b1, 32'h0BAD_F00D, 5'b10101, 0);
      // R9 start while busy
      apply("R9 short", 2'd2, 2'd0, 1'b0, 32'h0000_0005, 5'b00000, 1);
      apply("R9 long", 2'd0, 2'd2, 1'b1, 32'h7000_0000, 5'b10000, 1);

      // R7 random mix
      for (int i = 0; i < 400; i++) begin
         logic [1:0] rop, rsz;
         logic [31:0] ra;
         rop = 2'($urandom);
         rsz = 2'($urandom);
         ra  = $urandom;
         if ((i % 7) == 0) ra = ra & 32'hFFFF_FF00;
         apply("R7 random", rop, rsz, 1'($urandom), ra, 5'($urandom), 0);
      end

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule